// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a small register bus inside a system controller. A down-counter steps once on each cycle where the tick strobe is high and the halt control is clear. When the counter passes zero it reloads from a programmed initial value. The first such expiry sets a timeout flag and can raise an interrupt. If the counter expires again before software clears that flag, the block records a second timeout and requests a system reset. A no-reboot control bit can block that reset request.

Software arms the block with four steps. It programs the initial value, clears the halt bit, clears the no-reboot bit, and then services the timer by writing the reload key. Each service restarts the countdown. Clearing the first-stage flag means two more full countdowns must pass before a reset request. The bus carries 16-bit words with two byte enables. Writes take effect on the clock edge, and read data is combinational from the word address. Out of reset the timer is halted, reboot is blocked and every flag is clear, so nothing can fire before software arms it.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the registers read as follows, and both `irq_o` and `rst_req_o` are low.
  - Control word 4 reads 0x0800 (halt set).
  - Control word 5 reads 0x0001 (no-reboot set).
  - Status words 2 and 3 read 0.
  - The initial-value word 1 reads 50.
  - The count word 0 reads 50.
- R2: Word 1 holds a 10-bit initial value in bits 9:0 and six plain storage bits in 15:10. A read of word 1 returns exactly what the register holds.
- R3: A write to word 1 whose resulting bits 9:0 are 0, 1, 2 or 3 leaves bits 9:0 unchanged. Bits 15:10 still take the written value.
- R4: While bit 11 of word 4 is 1, ticks do not change the counter. When that bit is 0, each tick decrements the counter by one.
- R5: A write to word 0 with byte lane 0 enabled and low byte equal to 0x01 loads the counter with the initial value. Any other write to word 0 has no effect on the counter.
- R6: Word 0 reads the current counter in bits 9:0. A tick that arrives while the counter is 0 is an expiry. An expiry reloads the counter from the initial value.
- R7: An expiry while bit 3 of word 2 is clear is a first expiry. A first expiry sets bit 3 of word 2. It also sets `irq_o` if `smi_en_i` is high in that cycle. If `smi_en_i` is low, only the status bit changes.
- R8: An expiry while bit 3 of word 2 is set is a second expiry. A second expiry sets bit 1 (second timeout) and bit 2 (boot status) of word 3. It also raises `rst_req_o` unless bit 0 of word 5 (no-reboot) is 1.
- R9: Status bits are write-one-to-clear through byte lane 0; writing 0 changes nothing.
  - Clearing bit 3 of word 2 also drops `irq_o`.
  - After that clear, two more expiries are needed before a reset request.
- R10: Once raised, `rst_req_o` stays high until `rst_ni` is asserted. Clearing status does not release it.
- R11: A write changes only the bytes whose byte enable is set: `be_i[0]` selects bits 7:0 and `be_i[1]` selects bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables |
| rdata_o | output | 16 | Read data for `addr_i` |
| tick_i | input | 1 | Count strobe, one cycle per timer step |
| smi_en_i | input | 1 | Enables the interrupt on a first expiry |
| irq_o | output | 1 | Interrupt, held until the first-stage flag is cleared |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
A wrong counter value is visible on word 0 at the very next read, and it shifts the expiry tick that follows. A stale or misset first-stage flag changes which expiry is counted as the second one. That fault appears at `rst_req_o` and in word 3 within one countdown period of the initial value. A faulty byte-lane merge or a faulty floor check on the initial value shows up on the read-back of word 1 right after the write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_INIT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STS1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STS2  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL2 = 3'd5;

  localparam int HALT_BIT = 11;
  localparam int TO1_BIT  = 3;
  localparam int TO2_BIT  = 1;
  localparam int BOOT_BIT = 2;
  localparam int NR_BIT   = 0;
  localparam logic [7:0] RELOAD_KEY = 8'h01;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int INIT_DEF = 50,
  parameter int INIT_MIN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              to1_i,
  input  logic              to2_i,
  input  logic              boot_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              halt_o,
  output logic              no_reboot_o,
  output logic              reload_o,
  output logic              clr_to1_o,
  output logic              clr_to2_o,
  output logic              clr_boot_o
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] init_q, init_mrg, init_d;
  logic              halt_q, nr_q;
  logic              wr_init, wr_ctrl1, wr_ctrl2;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign init_mrg[b*8 +: 8] = be_i[b] ? wdata_i[b*8 +: 8] : init_q[b*8 +: 8];
  end

  // field below floor keeps old value, storage bits still follow the write
  always_comb begin
    if (init_mrg[CNT_W-1:0] >= CNT_W'(INIT_MIN)) init_d = init_mrg;
    else init_d = {init_mrg[DATA_W-1:CNT_W], init_q[CNT_W-1:0]};
  end

  assign wr_init  = we_i && (addr_i == A_INIT);
  assign wr_ctrl1 = we_i && (addr_i == A_CTRL1) && be_i[HALT_BIT/8];
  assign wr_ctrl2 = we_i && (addr_i == A_CTRL2) && be_i[0];

  assign reload_o   = we_i && (addr_i == A_COUNT) && be_i[0] && (wdata_i[7:0] == RELOAD_KEY);
  assign clr_to1_o  = we_i && (addr_i == A_STS1) && be_i[0] && wdata_i[TO1_BIT];
  assign clr_to2_o  = we_i && (addr_i == A_STS2) && be_i[0] && wdata_i[TO2_BIT];
  assign clr_boot_o = we_i && (addr_i == A_STS2) && be_i[0] && wdata_i[BOOT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= DATA_W'(INIT_DEF);
      halt_q <= 1'b1;
      nr_q   <= 1'b1;
    end else begin
      if (wr_init)  init_q <= init_d;
      if (wr_ctrl1) halt_q <= wdata_i[HALT_BIT];
      if (wr_ctrl2) nr_q   <= wdata_i[NR_BIT];
    end
  end

  assign init_o      = init_q[CNT_W-1:0];
  assign halt_o      = halt_q;
  assign no_reboot_o = nr_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_COUNT: rdata_o[CNT_W-1:0] = count_i;
      A_INIT:  rdata_o = init_q;
      A_STS1:  rdata_o[TO1_BIT] = to1_i;
      A_STS2: begin
        rdata_o[TO2_BIT]  = to2_i;
        rdata_o[BOOT_BIT] = boot_i;
      end
      A_CTRL1: rdata_o[HALT_BIT] = halt_q;
      A_CTRL2: rdata_o[NR_BIT] = nr_q;
      default: rdata_o = '0;
    endcase
  end

  a_r3_init_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o >= CNT_W'(INIT_MIN));
  a_r11_lane_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_init && !be_i[1]) |=> init_q[DATA_W-1:8] == $past(init_q[DATA_W-1:8]));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_DEF = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             run;

  assign run      = tick_i && !halt_i;
  assign expire_o = run && !reload_i && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          count_q <= CNT_W'(INIT_DEF);
    else if (reload_i)    count_q <= init_i;
    else if (run) begin
      if (count_q == '0)  count_q <= init_i;
      else                count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;

  a_r5_reload_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> count_o == $past(init_i));
  a_r4_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !reload_i) |=> $stable(count_o));
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic smi_en_i,
  input  logic no_reboot_i,
  input  logic clr_to1_i,
  input  logic clr_to2_i,
  input  logic clr_boot_i,
  output logic to1_o,
  output logic to2_o,
  output logic boot_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic to1_q, to2_q, boot_q, irq_q, rst_q;
  logic first, second;

  assign first  = expire_i && !to1_q;
  assign second = expire_i && to1_q;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to1_q  <= 1'b0;
      to2_q  <= 1'b0;
      boot_q <= 1'b0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      to1_q  <= first || (to1_q && !clr_to1_i);
      irq_q  <= (first && smi_en_i) || (irq_q && !clr_to1_i);
      to2_q  <= second || (to2_q && !clr_to2_i);
      boot_q <= second || (boot_q && !clr_boot_i);
      rst_q  <= rst_q || (second && !no_reboot_i);
    end
  end

  assign to1_o     = to1_q;
  assign to2_o     = to2_q;
  assign boot_o    = boot_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  a_r10_rst_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);
  a_r8_noreboot_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(!no_reboot_i && expire_i && to1_o));
  a_r7_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(smi_en_i && expire_i));
  a_r9_clear_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_to1_i && !expire_i) |=> (!to1_o && !irq_o));
  a_r8_second_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && to1_o) |=> (to2_o && boot_o));
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int INIT_DEF = 50,
  parameter int INIT_MIN = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  logic [1:0]  be_i,
  output logic [15:0] rdata_o,
  input  logic        tick_i,
  input  logic        smi_en_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic [CNT_W-1:0] count, init_val;
  logic halt, no_reboot, reload, expire;
  logic clr_to1, clr_to2, clr_boot;
  logic to1, to2, boot;

  wdt_regs #(.CNT_W(CNT_W), .INIT_DEF(INIT_DEF), .INIT_MIN(INIT_MIN)) regs_i (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .be_i,
    .count_i(count), .to1_i(to1), .to2_i(to2), .boot_i(boot),
    .rdata_o, .init_o(init_val), .halt_o(halt), .no_reboot_o(no_reboot),
    .reload_o(reload), .clr_to1_o(clr_to1), .clr_to2_o(clr_to2), .clr_boot_o(clr_boot)
  );

  wdt_counter #(.CNT_W(CNT_W), .INIT_DEF(INIT_DEF)) cnt_i (
    .clk_i, .rst_ni, .tick_i, .halt_i(halt), .reload_i(reload),
    .init_i(init_val), .count_o(count), .expire_o(expire)
  );

  wdt_status sts_i (
    .clk_i, .rst_ni, .expire_i(expire), .smi_en_i, .no_reboot_i(no_reboot),
    .clr_to1_i(clr_to1), .clr_to2_i(clr_to2), .clr_boot_i(clr_boot),
    .to1_o(to1), .to2_o(to2), .boot_o(boot), .irq_o, .rst_req_o
  );

  a_r1_quiet_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !reload) |=> !$rose(irq_o));
endmodule

// File: tb/wdt_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdt_two_stage_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic we_i = 1'b0, tick_i = 1'b0, smi_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0] be_i = '0;
  logic [15:0] rdata_o;
  logic irq_o, rst_req_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_init_full;
  logic [9:0]  m_cnt;
  bit m_to1, m_to2, m_boot, m_irq, m_rst, m_halt, m_nr;

  always #2 clk = ~clk;

  wdt_two_stage dut_i (
    .clk_i(clk), .rst_ni, .we_i, .addr_i, .wdata_i, .be_i, .rdata_o,
    .tick_i, .smi_en_i, .irq_o, .rst_req_o
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_init_full = 16'd50; m_cnt = 10'd50;
    m_to1 = 0; m_to2 = 0; m_boot = 0; m_irq = 0; m_rst = 0; m_halt = 1; m_nr = 1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; we_i = 0; tick_i = 0;
    @(negedge clk); @(negedge clk); rst_ni = 1'b1;
    model_reset();
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] mrg;
    @(negedge clk); we_i = 1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk); we_i = 0;
    case (a)
      3'd0: if (be[0] && d[7:0] == 8'h01) m_cnt = m_init_full[9:0];
      3'd1: begin
        mrg[7:0]  = be[0] ? d[7:0]  : m_init_full[7:0];
        mrg[15:8] = be[1] ? d[15:8] : m_init_full[15:8];
        if (mrg[9:0] >= 10'd4) m_init_full = mrg;
        else m_init_full = {mrg[15:10], m_init_full[9:0]};
      end
      3'd2: if (be[0] && d[3]) begin m_to1 = 0; m_irq = 0; end
      3'd3: if (be[0]) begin if (d[1]) m_to2 = 0; if (d[2]) m_boot = 0; end
      3'd4: if (be[1]) m_halt = d[11];
      3'd5: if (be[0]) m_nr = d[0];
      default: ;
    endcase
  endtask

  task automatic do_tick(input bit s);
    @(negedge clk); tick_i = 1; smi_en_i = s;
    @(negedge clk); tick_i = 0;
    if (!m_halt) begin
      if (m_cnt == 0) begin
        m_cnt = m_init_full[9:0];
        if (m_to1) begin
          m_to2 = 1; m_boot = 1;
          if (!m_nr) m_rst = 1;
        end else begin
          m_to1 = 1;
          if (s) m_irq = 1;
        end
      end else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic check_all(input string tag);
    logic [15:0] d;
    rd(3'd0, d); check({tag, " count"}, d, {6'b0, m_cnt});
    rd(3'd2, d); check({tag, " sts1"}, d, {12'b0, m_to1, 3'b0});
    rd(3'd3, d); check({tag, " sts2"}, d, {13'b0, m_boot, m_to2, 1'b0});
    rd(3'd1, d); check({tag, " init"}, d, m_init_full);
    check({tag, " irq"}, {15'b0, irq_o}, {15'b0, m_irq});
    check({tag, " rst_req"}, {15'b0, rst_req_o}, {15'b0, m_rst});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd7341));
    do_reset();

    // R1 reset state
    rd(3'd4, d); check("R1 ctrl1", d, 16'h0800);
    rd(3'd5, d); check("R1 ctrl2", d, 16'h0001);
    rd(3'd1, d); check("R1 init", d, 16'd50);
    rd(3'd0, d); check("R1 count", d, 16'd50);
    check_all("R1");

    // R2 storage bits and field read back
    wr(3'd1, 16'hA40A, 2'b11); rd(3'd1, d); check("R2 init readback", d, 16'hA40A);
    // R3 small value rejected, upper bits follow
    wr(3'd1, 16'h0003, 2'b11); rd(3'd1, d); check("R3 init floor", d, 16'h000A);
    wr(3'd1, 16'h0000, 2'b11); rd(3'd1, d); check("R3 init zero", d, 16'h000A);
    // R11 byte lanes
    wr(3'd1, 16'hFF00, 2'b10); rd(3'd1, d); check("R11 upper lane", d, 16'hFF0A);
    wr(3'd1, 16'h1105, 2'b01); rd(3'd1, d); check("R11 lower lane", d, 16'hFF05);
    wr(3'd1, 16'h0005, 2'b11); rd(3'd1, d); check("R2 init set", d, 16'h0005);

    // R4 halted: ticks ignored
    repeat (3) do_tick(1);
    rd(3'd0, d); check("R4 halted count", d, 16'd50);
    // R5 reload key and non-key
    wr(3'd0, 16'h0001, 2'b01); rd(3'd0, d); check("R5 reload", d, 16'd5);
    wr(3'd1, 16'h0007, 2'b11);
    wr(3'd0, 16'h0002, 2'b01); rd(3'd0, d); check("R5 bad key", d, 16'd5);
    wr(3'd0, 16'h0001, 2'b10); rd(3'd0, d); check("R5 lane off", d, 16'd5);

    // R4/R6 run down, first expiry with interrupt (R7)
    wr(3'd4, 16'h0000, 2'b10);
    do_tick(1); rd(3'd0, d); check("R4 decrement", d, 16'd4);
    repeat (4) do_tick(1);
    check_all("R6 at zero");
    do_tick(1);
    check_all("R7 first expiry");
    check("R7 irq high", {15'b0, irq_o}, 16'd1);
    // R8 second expiry, reboot blocked
    repeat (8) do_tick(1);
    check_all("R8 blocked");
    check("R8 rst low", {15'b0, rst_req_o}, 16'd0);
    // R9 write 0 no effect, then W1C
    wr(3'd2, 16'h0000, 2'b01); wr(3'd3, 16'h0000, 2'b01);
    check_all("R9 zero write");
    wr(3'd2, 16'h0008, 2'b01); wr(3'd3, 16'h0006, 2'b01);
    check_all("R9 cleared");
    check("R9 irq low", {15'b0, irq_o}, 16'd0);

    // R7 no interrupt when disabled; R8 reset when enabled; R10 sticky
    wr(3'd5, 16'h0000, 2'b01);
    wr(3'd0, 16'h0001, 2'b01);
    repeat (8) do_tick(0);
    check_all("R7 smi off");
    check("R7 irq stays low", {15'b0, irq_o}, 16'd0);
    repeat (8) do_tick(0);
    check_all("R8 reset request");
    check("R8 rst high", {15'b0, rst_req_o}, 16'd1);
    wr(3'd2, 16'h0008, 2'b01); wr(3'd3, 16'h0006, 2'b01);
    check_all("R10 sticky");
    check("R10 rst held", {15'b0, rst_req_o}, 16'd1);
    // R9 clearing restores two full countdowns
    do_reset();
    wr(3'd1, 16'h0004, 2'b11); wr(3'd4, 16'h0000, 2'b10); wr(3'd5, 16'h0000, 2'b01);
    wr(3'd0, 16'h0001, 2'b01);
    repeat (5) do_tick(1);
    wr(3'd2, 16'h0008, 2'b01);
    repeat (5) do_tick(1);
    check("R9 no reset after clear", {15'b0, rst_req_o}, 16'd0);
    check_all("R9 restart");

    // constrained random
    do_reset();
    wr(3'd1, 16'(4 + $urandom_range(0, 8)), 2'b11);
    wr(3'd4, 16'h0000, 2'b10);
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 65)      do_tick(1'($urandom_range(0, 1)));
      else if (sel < 75) wr(3'd0, 16'h0001, 2'b01);
      else if (sel < 80) wr(3'd2, 16'(8 * $urandom_range(0, 1)), 2'($urandom_range(0, 3)));
      else if (sel < 84) wr(3'd3, 16'($urandom_range(0, 7)), 2'($urandom_range(0, 3)));
      else if (sel < 88) wr(3'd1, 16'($urandom_range(0, 15)), 2'($urandom_range(0, 3)));
      else if (sel < 92) wr(3'd4, 16'(2048 * $urandom_range(0, 1)), 2'b10);
      else if (sel < 97) wr(3'd5, 16'($urandom_range(0, 1)), 2'b01);
      else               wr(3'd0, 16'($urandom_range(2, 255)), 2'b01);
      check_all("R6 random");
      if (m_rst && $urandom_range(0, 3) == 0) do_reset();
    end
    finish_run();
  end
endmodule